// File: doc/BRIEF.md
# Low-Power DDR Power-Up Initialization Sequencer

This block walks an LPDDR2 or LPDDR3 memory through its power-up procedure in hardware and then hands it over to normal operation. A single start pulse launches a fixed sequence of commands toward the memory controller core. The sequence has an idle command, timed waits, a device reset and a ZQ calibration. It then writes four mode registers, reads back four more under a raised pair of configuration bits, and switches to normal mode. The last step loads the refresh-interval register.

Each command goes out as a mode code and a mode-register address, held with a request strobe until the controller core acknowledges it. Waits are counted by a microsecond timer whose cycle counts are fixed at elaboration from the timer clock frequency. The refresh interval is computed by dividing a parameterised tREFI by the clock period supplied on an input. A watchdog flags any command that waits too long for its acknowledge.

Top module: `lpddr_init_seq`

## Requirements
- R1: A start pulse while idle raises busy on the next cycle and drives mem_type with 7 when dev_lp3 is 0 (LPDDR2) or 5 when dev_lp3 is 1 (LPDDR3). A start pulse while busy is ignored: mem_type holds and the sequence continues unchanged.
- R2: cmd_req stays high with cmd_mode and cmd_addr stable until cmd_ack is seen high at a clock edge. The next step begins on that edge.
- R3: Commands go out in this order as (cmd_mode, cmd_addr): (1,0), (1,0), (7,63), (7,10), (7,1), (7,2), (7,3), (7,16), (1,0), (7,5), (7,6), (7,8), (7,0), (0,0). Mode 1 is the idle command, mode 7 is a mode-register access and mode 0 is normal operation.
- R4: After the acknowledge of the first idle command, the second idle command and the reset command, cmd_req stays low for exactly round(((TIMER_HZ/1000)*us)/1000) cycles, with a minimum of 1. The us value is 1, 200 and 500 respectively. The requests that follow calibration go out with no gap, except for the single-cycle step that raises side_cfg.
- R5: zq_ctl is 0 from start until the calibration command (7,10). It is 3 while that command is requested and 2 from the cycle after its acknowledge onward.
- R6: side_cfg is 2'b00 through the write to mode register 16. It is 2'b11 from the idle command that follows through the normal-mode command. It is back to 2'b00 before refresh load.
- R7: The cmd_rdata present at the acknowledge of the k-th mode-register read is kept in mr_data[k*MRD_W +: MRD_W]. k is 0 for address 5, 1 for address 6, 2 for address 8 and 3 for address 0.
- R8: refr_load pulses for one cycle with refr_count = floor(TREFI_PS / tck_ps), where tck_ps is sampled at start. A result above 2^RC_W-1 becomes 2^RC_W-1, and tck_ps = 0 gives 2^RC_W-1.
- R9: done is high for exactly the one cycle after refr_load, and busy is low in that cycle.
- R10: err goes high once cmd_req has been high without cmd_ack for ACK_TIMEOUT consecutive cycles. The sequence still waits for the acknowledge. err is cleared by the next accepted start.
- R11: After reset, busy, done, cmd_req, refr_load and err are 0, and side_cfg, zq_ctl, mem_type, refr_count and mr_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| dev_lp3 | input | 1 | Device select: 0 LPDDR2, 1 LPDDR3 |
| tck_ps | input | TCK_W | Memory clock period in picoseconds |
| mem_type | output | 3 | Device-type code for the controller |
| busy | output | 1 | Sequence in progress |
| cmd_req | output | 1 | Command request strobe |
| cmd_mode | output | 3 | Command mode code |
| cmd_addr | output | 6 | Mode-register address |
| zq_ctl | output | 2 | Calibration control field |
| cmd_ack | input | 1 | Command acknowledge from controller core |
| cmd_rdata | input | MRD_W | Mode-register read data, valid with cmd_ack |
| side_cfg | output | 2 | Side configuration bit pair |
| refr_load | output | 1 | Refresh-interval load strobe |
| refr_count | output | RC_W | Refresh interval in clock cycles |
| mr_data | output | 4*MRD_W | Captured mode-register read results |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Acknowledge timeout flag |

## Verification
The bench builds the block with a 2.5 MHz timer clock, which turns the three waits into 3, 500 and 1250 cycles. The 1 µs case lands on an exact half and so shows the rounding. tREFI is 3900 ps with a 10-bit refresh count, so period sweeps reach saturation, a zero divisor, a quotient of one and a quotient of zero. The acknowledge timeout is 8, so holding back an acknowledge for 7 and then for 8 or more cycles shows both sides of the limit. The default iterative divider is used.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

   localparam int MRA_W  = 6;
   localparam int STEP_W = 5;

   localparam logic [2:0] MODE_NORMAL = 3'd0;
   localparam logic [2:0] MODE_NOP    = 3'd1;
   localparam logic [2:0] MODE_MRACC  = 3'd7;

   localparam logic [STEP_W-1:0] STEP_ZQ  = 5'd3;
   localparam logic [STEP_W-1:0] STEP_RD0 = 5'd10;

   typedef enum logic [1:0] {K_CMD, K_SIDE_ON, K_SIDE_OFF, K_REFR} kind_e;
   typedef enum logic [1:0] {W_NONE, W_1US, W_200US, W_500US} wsel_e;
   typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAIT, S_SIDE, S_DIVGO, S_DIVW, S_FIN} st_e;

   typedef struct packed {
      kind_e             kind;
      logic [2:0]        mode;
      logic [MRA_W-1:0]  addr;
      wsel_e             wsel;
      logic              rd;
   } step_t;

   function automatic step_t mk(input kind_e k, input logic [2:0] m,
                                input logic [MRA_W-1:0] a, input wsel_e w,
                                input logic r);
      step_t s;
      s.kind = k;
      s.mode = m;
      s.addr = a;
      s.wsel = w;
      s.rd   = r;
      return s;
   endfunction

   // Sequence order is behaviour: the index walks this table top to bottom.
   function automatic step_t step_info(input logic [STEP_W-1:0] idx);
      case (idx)
         5'd0:    return mk(K_CMD,      MODE_NOP,    6'd0,  W_1US,   1'b0);
         5'd1:    return mk(K_CMD,      MODE_NOP,    6'd0,  W_200US, 1'b0);
         5'd2:    return mk(K_CMD,      MODE_MRACC,  6'd63, W_500US, 1'b0);
         5'd3:    return mk(K_CMD,      MODE_MRACC,  6'd10, W_NONE,  1'b0);
         5'd4:    return mk(K_CMD,      MODE_MRACC,  6'd1,  W_NONE,  1'b0);
         5'd5:    return mk(K_CMD,      MODE_MRACC,  6'd2,  W_NONE,  1'b0);
         5'd6:    return mk(K_CMD,      MODE_MRACC,  6'd3,  W_NONE,  1'b0);
         5'd7:    return mk(K_CMD,      MODE_MRACC,  6'd16, W_NONE,  1'b0);
         5'd8:    return mk(K_SIDE_ON,  MODE_NORMAL, 6'd0,  W_NONE,  1'b0);
         5'd9:    return mk(K_CMD,      MODE_NOP,    6'd0,  W_NONE,  1'b0);
         5'd10:   return mk(K_CMD,      MODE_MRACC,  6'd5,  W_NONE,  1'b1);
         5'd11:   return mk(K_CMD,      MODE_MRACC,  6'd6,  W_NONE,  1'b1);
         5'd12:   return mk(K_CMD,      MODE_MRACC,  6'd8,  W_NONE,  1'b1);
         5'd13:   return mk(K_CMD,      MODE_MRACC,  6'd0,  W_NONE,  1'b1);
         5'd14:   return mk(K_CMD,      MODE_NORMAL, 6'd0,  W_NONE,  1'b0);
         5'd15:   return mk(K_SIDE_OFF, MODE_NORMAL, 6'd0,  W_NONE,  1'b0);
         default: return mk(K_REFR,     MODE_NORMAL, 6'd0,  W_NONE,  1'b0);
      endcase
   endfunction

   function automatic kind_e kind_of(input logic [STEP_W-1:0] idx);
      step_t s;
      s = step_info(idx);
      return s.kind;
   endfunction

   function automatic st_e kind_state(input kind_e k);
      case (k)
         K_CMD:     return S_CMD;
         K_REFR:    return S_DIVGO;
         default:   return S_SIDE;
      endcase
   endfunction

   // Rounded cycle count of a wait; never below one cycle.
   function automatic longint unsigned wait_cycles(input longint unsigned hz,
                                                   input longint unsigned us);
      longint unsigned c;
      c = ((hz / 1000) * us + 500) / 1000;
      if (c == 0) c = 1;
      return c;
   endfunction

endpackage

// File: rtl/lpi_us_timer.sv
module lpi_us_timer
   import lpi_pkg::*;
#(
   parameter longint unsigned TIMER_HZ = 100_000_000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  arm,
   input  wsel_e sel,
   output logic  expire
);
   localparam longint unsigned D1   = wait_cycles(TIMER_HZ, 1);
   localparam longint unsigned D200 = wait_cycles(TIMER_HZ, 200);
   localparam longint unsigned D500 = wait_cycles(TIMER_HZ, 500);
   localparam int CW = (D500 < 2) ? 1 : $clog2(D500 + 1);

   if (TIMER_HZ < 1000) begin : g_bad_hz
      $error("lpi_us_timer: TIMER_HZ must be at least 1000");
   end

   logic [CW-1:0] cnt_q, lim_q, lim_d;
   logic          run_q;

   always_comb begin
      case (sel)
         W_1US:   lim_d = CW'(D1 - 1);
         W_200US: lim_d = CW'(D200 - 1);
         W_500US: lim_d = CW'(D500 - 1);
         default: lim_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
         run_q <= 1'b0;
      end else if (arm) begin
         cnt_q <= '0;
         lim_q <= lim_d;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == lim_q) run_q <= 1'b0;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run_q && (cnt_q == lim_q);

endmodule

// File: rtl/lpi_ack_watch.sv
module lpi_ack_watch #(
   parameter int TIMEOUT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic req,
   input  logic ack,
   output logic err
);
   localparam int CW = $clog2(TIMEOUT + 1);

   if (TIMEOUT < 2) begin : g_bad_to
      $error("lpi_ack_watch: TIMEOUT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err   <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         err   <= 1'b0;
      end else if (!req || ack) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(TIMEOUT - 1)) begin
         err   <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/lpi_div.sv
module lpi_div #(
   parameter int NUM_W = 23,
   parameter int DEN_W = 16,
   parameter int Q_W   = 16,
   parameter bit FAST  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [Q_W-1:0]   quo
);
   localparam int DW = (NUM_W > DEN_W) ? NUM_W : DEN_W;

   if (NUM_W < 2) begin : g_bad_num
      $error("lpi_div: NUM_W must be at least 2");
   end

   logic [NUM_W-1:0] q_q;

   if (FAST) begin : g_fast
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_q  <= '0;
            done <= 1'b0;
         end else begin
            done <= start;
            if (start) begin
               if (den == '0) q_q <= '1;
               else           q_q <= NUM_W'(DW'(num) / DW'(den));
            end
         end
      end
   end else begin : g_iter
      localparam int CW = $clog2(NUM_W);
      logic [DEN_W-1:0] rem_q;
      logic [NUM_W-1:0] nsh_q;
      logic [CW-1:0]    cnt_q;
      logic             run_q;
      logic [DEN_W:0]   trial;
      logic             ge;

      always_comb begin
         trial = {rem_q, nsh_q[NUM_W-1]};
         ge    = trial >= {1'b0, den};
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q <= '0;
            nsh_q <= '0;
            q_q   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
         end else begin
            done <= 1'b0;
            if (start) begin
               rem_q <= '0;
               nsh_q <= num;
               q_q   <= '0;
               cnt_q <= '0;
               run_q <= 1'b1;
            end else if (run_q) begin
               rem_q <= ge ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
               nsh_q <= nsh_q << 1;
               q_q   <= {q_q[NUM_W-2:0], ge};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(NUM_W - 1)) begin
                  run_q <= 1'b0;
                  done  <= 1'b1;
               end
            end
         end
      end
   end

   if (NUM_W > Q_W) begin : g_sat
      assign quo = (|q_q[NUM_W-1:Q_W]) ? '1 : q_q[Q_W-1:0];
   end else begin : g_wide
      assign quo = Q_W'(q_q);
   end

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
   import lpi_pkg::*;
#(
   parameter longint unsigned TIMER_HZ    = 100_000_000,
   parameter longint unsigned TREFI_PS    = 7_800_000,
   parameter int              TCK_W       = 16,
   parameter int              RC_W        = 16,
   parameter int              MRD_W       = 8,
   parameter int              ACK_TIMEOUT = 4096,
   parameter bit              FAST_DIV    = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 dev_lp3,
   input  logic [TCK_W-1:0]     tck_ps,
   output logic [2:0]           mem_type,
   output logic                 busy,
   output logic                 cmd_req,
   output logic [2:0]           cmd_mode,
   output logic [5:0]           cmd_addr,
   output logic [1:0]           zq_ctl,
   input  logic                 cmd_ack,
   input  logic [MRD_W-1:0]     cmd_rdata,
   output logic [1:0]           side_cfg,
   output logic                 refr_load,
   output logic [RC_W-1:0]      refr_count,
   output logic [4*MRD_W-1:0]   mr_data,
   output logic                 done,
   output logic                 err
);
   localparam int RD_SLOTS = 4;
   localparam int NUM_W    = $clog2(TREFI_PS + 1);
   localparam logic [NUM_W-1:0] TREFI_V = NUM_W'(TREFI_PS);

   if (TCK_W < 1 || RC_W < 1 || MRD_W < 1) begin : g_bad_w
      $error("lpddr_init_seq: widths must be positive");
   end
   if (TREFI_PS < 2) begin : g_bad_trefi
      $error("lpddr_init_seq: TREFI_PS must be at least 2");
   end

   st_e               state_q;
   logic [STEP_W-1:0] step_q, step_nx;
   step_t             cur;
   kind_e             nxt_kind;
   logic              adv, tmr_arm, tmr_exp, div_done, accept;
   logic [RC_W-1:0]   div_quo;
   logic [TCK_W-1:0]  tck_q;
   logic [1:0]        slot;
   logic [2:0]        type_q;
   logic [1:0]        zq_q, side_q;
   logic [RC_W-1:0]   rc_q;
   logic              load_q, done_q;
   logic [MRD_W-1:0]  mr_q [RD_SLOTS];

   always_comb begin
      step_nx  = step_q + 5'd1;
      cur      = step_info(step_q);
      nxt_kind = kind_of(step_nx);
      slot     = 2'(step_q - STEP_RD0);
      accept   = (state_q == S_IDLE) && start;
      tmr_arm  = (state_q == S_CMD) && cmd_ack && (cur.wsel != W_NONE);
      adv      = ((state_q == S_CMD) && cmd_ack && (cur.wsel == W_NONE))
              || ((state_q == S_WAIT) && tmr_exp)
              ||  (state_q == S_SIDE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         step_q  <= '0;
         type_q  <= '0;
         zq_q    <= '0;
         side_q  <= '0;
         rc_q    <= '0;
         load_q  <= 1'b0;
         done_q  <= 1'b0;
         tck_q   <= '0;
         for (int i = 0; i < RD_SLOTS; i++) mr_q[i] <= '0;
      end else begin
         load_q <= 1'b0;
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start) begin
                  state_q <= S_CMD;
                  step_q  <= '0;
                  type_q  <= dev_lp3 ? 3'd5 : 3'd7;
                  zq_q    <= 2'd0;
                  tck_q   <= tck_ps;
               end
            end
            S_CMD: begin
               if (cmd_ack) begin
                  if (cur.rd) mr_q[slot] <= cmd_rdata;
                  if (step_q == STEP_ZQ) zq_q <= 2'd2;
                  if (cur.wsel != W_NONE) state_q <= S_WAIT;
               end
            end
            S_SIDE:  side_q  <= (cur.kind == K_SIDE_ON) ? 2'b11 : 2'b00;
            S_DIVGO: state_q <= S_DIVW;
            S_DIVW: begin
               if (div_done) begin
                  rc_q    <= div_quo;
                  load_q  <= 1'b1;
                  state_q <= S_FIN;
               end
            end
            S_FIN: begin
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: ;
         endcase
         if (adv) begin
            step_q  <= step_nx;
            state_q <= kind_state(nxt_kind);
            if (step_nx == STEP_ZQ) zq_q <= 2'd3;
         end
      end
   end

   lpi_us_timer #(.TIMER_HZ(TIMER_HZ)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (tmr_arm),
      .sel    (cur.wsel),
      .expire (tmr_exp)
   );

   lpi_div #(.NUM_W(NUM_W), .DEN_W(TCK_W), .Q_W(RC_W), .FAST(FAST_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (state_q == S_DIVGO),
      .num   (TREFI_V),
      .den   (tck_q),
      .done  (div_done),
      .quo   (div_quo)
   );

   lpi_ack_watch #(.TIMEOUT(ACK_TIMEOUT)) u_watch (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .req   (cmd_req),
      .ack   (cmd_ack),
      .err   (err)
   );

   for (genvar g = 0; g < RD_SLOTS; g++) begin : g_mr
      assign mr_data[g*MRD_W +: MRD_W] = mr_q[g];
   end

   assign busy       = (state_q != S_IDLE);
   assign cmd_req    = (state_q == S_CMD);
   assign cmd_mode   = cur.mode;
   assign cmd_addr   = cur.addr;
   assign zq_ctl     = zq_q;
   assign side_cfg   = side_q;
   assign mem_type   = type_q;
   assign refr_count = rc_q;
   assign refr_load  = load_q;
   assign done       = done_q;

endmodule

// File: rtl/lpi_checker.sv
module lpi_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic [2:0] mem_type,
   input logic       cmd_req,
   input logic       cmd_ack,
   input logic [2:0] cmd_mode,
   input logic [5:0] cmd_addr,
   input logic [1:0] zq_ctl,
   input logic [1:0] side_cfg,
   input logic       refr_load,
   input logic       done,
   input logic       err
);

   assert_type_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mem_type));

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_mode) && $stable(cmd_addr)));

   assert_zq_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_mode == 3'd7 && cmd_addr == 6'd10) |-> (zq_ctl == 2'd3));

   assert_zq_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_ack && cmd_mode == 3'd7 && cmd_addr == 6'd10) |=> (zq_ctl == 2'd2));

   assert_side_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (side_cfg == 2'b00) || (side_cfg == 2'b11));

   assert_side_low_at_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      refr_load |-> (side_cfg == 2'b00));

   assert_load_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      refr_load |=> !refr_load);

   assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      refr_load |=> (done && !busy));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (cmd_req && $past(cmd_req && !cmd_ack)));

endmodule

bind lpddr_init_seq lpi_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .mem_type  (mem_type),
   .cmd_req   (cmd_req),
   .cmd_ack   (cmd_ack),
   .cmd_mode  (cmd_mode),
   .cmd_addr  (cmd_addr),
   .zq_ctl    (zq_ctl),
   .side_cfg  (side_cfg),
   .refr_load (refr_load),
   .done      (done),
   .err       (err)
);

// File: tb/lpddr_init_seq_bench.sv
module lpddr_init_seq_bench;
   localparam longint unsigned HZ    = 2_500_000;
   localparam longint unsigned TREFI = 3900;
   localparam int TCK_W = 13;
   localparam int RC_W  = 10;
   localparam int MRD_W = 8;
   localparam int TO    = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n, start, dev_lp3, cmd_ack;
   logic [TCK_W-1:0]  tck_ps;
   logic [MRD_W-1:0]  cmd_rdata;
   logic [2:0]        mem_type, cmd_mode;
   logic [5:0]        cmd_addr;
   logic [1:0]        zq_ctl, side_cfg;
   logic              busy, cmd_req, refr_load, done, err;
   logic [RC_W-1:0]   refr_count;
   logic [4*MRD_W-1:0] mr_data;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   lpddr_init_seq #(
      .TIMER_HZ(HZ), .TREFI_PS(TREFI), .TCK_W(TCK_W), .RC_W(RC_W),
      .MRD_W(MRD_W), .ACK_TIMEOUT(TO), .FAST_DIV(1'b0)
   ) u_lpddr_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_lp3(dev_lp3), .tck_ps(tck_ps),
      .mem_type(mem_type), .busy(busy), .cmd_req(cmd_req), .cmd_mode(cmd_mode),
      .cmd_addr(cmd_addr), .zq_ctl(zq_ctl), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata),
      .side_cfg(side_cfg), .refr_load(refr_load), .refr_count(refr_count),
      .mr_data(mr_data), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint dl(input longint us);
      longint c;
      c = ((longint'(HZ) / 1000) * us + 500) / 1000;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int exp_mode(input int k);
      case (k)
         0, 1, 8: return 1;
         13:      return 0;
         default: return 7;
      endcase
   endfunction

   function automatic int exp_addr(input int k);
      case (k)
         2: return 63;  3: return 10;  4: return 1;  5: return 2;
         6: return 3;   7: return 16;  9: return 5;  10: return 6;
         11: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_gap(input int k);
      case (k)
         1: return int'(dl(1));
         2: return int'(dl(200));
         3: return int'(dl(500));
         8: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic longint exp_refr(input int tck);
      longint q, mx;
      mx = (longint'(1) << RC_W) - 1;
      if (tck == 0) return mx;
      q = longint'(TREFI) / tck;
      return (q > mx) ? mx : q;
   endfunction

   task automatic run(input bit dev, input int tck, input int slow_k, input int slow_d);
      logic [MRD_W-1:0] rd [4];
      int gap, d;
      logic [2:0] m0;
      logic [5:0] a0;
      @(negedge clk);
      start = 1'b1; dev_lp3 = dev; tck_ps = TCK_W'(tck);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R1 busy after start", busy, 1);
      chk(mem_type == (dev ? 3'd5 : 3'd7), "R1 type code", mem_type, dev ? 5 : 7);
      chk(err == 1'b0, "R10 err cleared by start", err, 0);
      for (int k = 0; k < 14; k++) begin
         gap = 0;
         while (!cmd_req && gap < 3000) begin
            @(negedge clk);
            gap++;
         end
         chk(gap == exp_gap(k), (k >= 1 && k <= 3) ? "R4 wait length" : "R4 back-to-back", gap, exp_gap(k));
         chk(int'(cmd_mode) == exp_mode(k), "R3 mode order", cmd_mode, exp_mode(k));
         chk(int'(cmd_addr) == exp_addr(k), "R3 address order", cmd_addr, exp_addr(k));
         chk(side_cfg == ((k >= 8) ? 2'b11 : 2'b00), "R6 side bits", side_cfg, (k >= 8) ? 3 : 0);
         if (k < 3) chk(zq_ctl == 2'd0, "R5 zq before calibration", zq_ctl, 0);
         if (k == 3) chk(zq_ctl == 2'd3, "R5 zq during calibration", zq_ctl, 3);
         d  = (k == slow_k) ? slow_d : (k % 3);
         m0 = cmd_mode;
         a0 = cmd_addr;
         for (int i = 0; i < d; i++) begin
            if (k == 4 && i == 0) begin
               start = 1'b1;
               dev_lp3 = ~dev;
            end
            @(negedge clk);
            start = 1'b0;
            chk(cmd_req && cmd_mode == m0 && cmd_addr == a0, "R2 request held", cmd_req, 1);
         end
         if (k == 4) chk(mem_type == (dev ? 3'd5 : 3'd7), "R1 start ignored while busy", mem_type, dev ? 5 : 7);
         cmd_ack = 1'b1;
         cmd_rdata = MRD_W'(tck * 7 + k * 13 + 1);
         if (k >= 9 && k <= 12) rd[k-9] = cmd_rdata;
         @(negedge clk);
         cmd_ack = 1'b0;
         cmd_rdata = '0;
         if (k == 3) chk(zq_ctl == 2'd2, "R5 zq after acknowledge", zq_ctl, 2);
      end
      gap = 0;
      while (!refr_load && gap < 200) begin
         @(negedge clk);
         gap++;
      end
      chk(refr_load == 1'b1, "R8 refresh load seen", refr_load, 1);
      chk(side_cfg == 2'b00, "R6 side cleared before load", side_cfg, 0);
      chk(longint'(refr_count) == exp_refr(tck), "R8 refresh count", refr_count, exp_refr(tck));
      @(negedge clk);
      chk(done == 1'b1, "R9 done after load", done, 1);
      chk(busy == 1'b0, "R9 busy low with done", busy, 0);
      chk(refr_load == 1'b0, "R8 load single cycle", refr_load, 0);
      @(negedge clk);
      chk(done == 1'b0, "R9 done single cycle", done, 0);
      for (int i = 0; i < 4; i++)
         chk(mr_data[i*MRD_W +: MRD_W] == rd[i], "R7 read capture", mr_data[i*MRD_W +: MRD_W], rd[i]);
      chk(err == (slow_k >= 0 && slow_d >= TO), "R10 timeout flag", err, (slow_k >= 0 && slow_d >= TO) ? 1 : 0);
      chk(zq_ctl == 2'd2, "R5 zq holds", zq_ctl, 2);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; dev_lp3 = 1'b0; tck_ps = '0;
      cmd_ack = 1'b0; cmd_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !cmd_req && !refr_load && !err, "R11 reset controls", {busy, done, cmd_req, refr_load, err}, 0);
      chk(side_cfg == 0 && zq_ctl == 0 && mem_type == 0, "R11 reset fields", {side_cfg, zq_ctl, mem_type}, 0);
      chk(refr_count == 0 && mr_data == 0, "R11 reset data", refr_count, 0);
      run(1'b0, 1,    -1, 0);
      run(1'b1, 3,     2, 8);
      run(1'b0, 5,     6, 7);
      run(1'b1, 7,    11, 9);
      run(1'b0, 0,    -1, 0);
      run(1'b1, 3900, -1, 0);
      run(1'b0, 4000, -1, 0);
      run(1'b1, 100,  -1, 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule